// File: doc/BRIEF.md
# Asynchronous Serial Port with Control Register

This block is a full-duplex asynchronous serial port steered by one 8-bit control register. Software picks the frame format through two mode bits, enables the receiver, supplies a ninth bit for outgoing 9-bit frames and reads back either the ninth received bit or the received stop bit. Two completion flags, one for transmit and one for receive, live in the same register and drive a single interrupt line.

A separate write strobe loads the transmit data byte. The last accepted received byte is always visible on a read port. Bit timing comes from an external tick that pulses once per oversampling slot (OSR slots per bit). In the 9-bit formats the receiver can filter for address frames, so a node only wakes up when a frame's ninth bit is set. The flags can only be cleared by writing a zero to them, so a read-modify-write that carries stale ones can never wipe out an event.

Top module: `sport_ctl`

## Requirements
- R1: The control register reads back as {mode[1], mode[0], addr_filter, rx_enable, tx_bit9, rx_bit9, tx_flag, rx_flag}, from bit 7 down to bit 0. After reset it reads 0x00, ser_tx is high and irq is low.
- R2: In mode 01, a write to the transmit data port sends one low start bit, then the 8 data bits LSB first, then one high stop bit. Each bit lasts OSR ticks. ser_tx is high whenever no frame is being sent.
- R3: In modes 10 and 11, tx_bit9 (bit 3), as it stands at the data write, is sent after the 8 data bits and before the stop bit.
- R4: In mode 00, transmit data writes are ignored (ser_tx stays high and tx_flag stays 0) and no frame is received.
- R5: tx_flag (bit 1) is set when the stop bit has been fully sent. When an accepted frame's stop bit is sampled, rx_flag (bit 0) is set and rxd_rdata takes the received byte. rxd_rdata changes at no other time.
- R6: Writing 1 to a flag bit has no effect. Writing 0 to a flag bit clears it. When hardware sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R7: rx_bit9 (bit 2) takes the ninth bit of each accepted 9-bit frame. In mode 01 with addr_filter at 0, it takes the received stop bit. Otherwise only a register write changes it.
- R8: In modes 10 and 11 with addr_filter (bit 5) at 1, a frame whose ninth bit is 0 is dropped: rx_flag, rxd_rdata and rx_bit9 keep their values.
- R9: While rx_enable (bit 4) is 0, no new frame is accepted.
- R10: A start bit that is no longer low at its midpoint (OSR/2 ticks) is discarded, and the receiver then accepts the next valid frame.
- R11: irq is high exactly when tx_flag or rx_flag is set.
- R12: A transmit data write that arrives while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| txd_we | input | 1 | Transmit data write strobe |
| txd_wdata | input | 8 | Transmit data byte |
| rxd_rdata | output | 8 | Last accepted received byte |
| baud_tick | input | 1 | One pulse per oversampling slot |
| ser_rx | input | 1 | Serial receive line (asynchronous) |
| ser_tx | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request (flag OR) |

## Verification
The bench builds the port with OSR at 8 and two synchronizer stages, and fires the tick every fourth clock. A frame is then only a few hundred cycles long, so dozens of looped-back frames fit in the run, covering random modes, filter settings and ninth bits. Because the line edges fall at every phase relative to the tick, the receiver's midpoint sampling is exercised against that jitter. The short bit time also makes it cheap to hold a zero-write on the flags for a whole frame, which lands a hardware flag-set on the same cycle as a clearing write.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // control register bit positions
  localparam int CB_M0  = 7;
  localparam int CB_M1  = 6;
  localparam int CB_MPE = 5;
  localparam int CB_REN = 4;
  localparam int CB_TB9 = 3;
  localparam int CB_RB9 = 2;
  localparam int CB_TF  = 1;
  localparam int CB_RF  = 0;

  typedef enum logic [1:0] {
    SM_NONE = 2'b00,
    SM_8V   = 2'b01,
    SM_9F   = 2'b10,
    SM_9V   = 2'b11
  } sp_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } sp_rx_st_e;

  function automatic logic sp_nine(sp_mode_e m);
    return (m == SM_9F) || (m == SM_9V);
  endfunction

  function automatic logic sp_active(sp_mode_e m);
    return m != SM_NONE;
  endfunction

  // total line bits in a frame, start and stop included
  function automatic logic [3:0] sp_frame_bits(logic nine);
    return nine ? 4'd11 : 4'd10;
  endfunction

  // a software write can only clear; a hardware set always wins
  function automatic logic sp_flag_next(logic cur, logic we, logic wbit, logic hw);
    return hw | (we ? (cur & wbit) : cur);
  endfunction

  // address filter: a 9-bit frame with bit 9 low is dropped while filtering
  function automatic logic sp_keep(logic nine, logic mpe, logic b9);
    return !(nine && mpe && !b9);
  endfunction

endpackage

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       nine,
  input  logic       tb9,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] CNT_END = CW'(OSR - 1);

  logic [10:0]   sh;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic          nine_q;
  logic [3:0]    last_idx;

  assign last_idx = sp_frame_bits(nine_q) - 4'd1;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      cnt    <= '0;
      idx    <= '0;
      nine_q <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          nine_q <= nine;
          sh     <= nine ? {1'b1, tb9, data, 1'b0} : {2'b11, data, 1'b0};
          cnt    <= '0;
          idx    <= '0;
        end
      end else if (tick) begin
        if (cnt == CNT_END) begin
          cnt <= '0;
          sh  <= {1'b1, sh[10:1]};
          if (idx == last_idx) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 4'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       arm,
  input  logic       nine,
  output logic       done,
  output logic [7:0] data,
  output logic       b9,
  output logic       stopb
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] CNT_END  = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OSR / 2 - 1);

  logic [SYNC-1:0] sy;
  logic            rx_s;
  sp_rx_st_e       st;
  logic [CW-1:0]   cnt;
  logic [3:0]      idx;
  logic [8:0]      sh;
  logic            nine_q;
  logic [3:0]      last_idx;

  assign rx_s     = sy[SYNC-1];
  assign last_idx = nine_q ? 4'd8 : 4'd7;

  // synchronizer chain, one flop per stage
  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy[g] <= 1'b1;
      else        sy[g] <= (g == 0) ? rxd : sy[(g == 0) ? 0 : g - 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      nine_q <= 1'b0;
      done   <= 1'b0;
      data   <= '0;
      b9     <= 1'b0;
      stopb  <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (arm && !rx_s) begin
            st     <= RX_START;
            cnt    <= '0;
            nine_q <= nine;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == CNT_HALF) begin
              cnt <= '0;
              idx <= '0;
              st  <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt <= '0;
              sh  <= {rx_s, sh[8:1]};
              idx <= idx + 4'd1;
              if (idx == last_idx) st <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == CNT_END) begin
              cnt   <= '0;
              done  <= 1'b1;
              stopb <= rx_s;
              data  <= nine_q ? sh[7:0] : sh[8:1];
              b9    <= nine_q ? sh[8] : 1'b0;
              st    <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sport_ctl.sv
module sport_ctl
  import sport_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       txd_we,
  input  logic [7:0] txd_wdata,
  output logic [7:0] rxd_rdata,
  input  logic       baud_tick,
  input  logic       ser_rx,
  output logic       ser_tx,
  output logic       irq
);
  logic [7:0] ctl_q;
  logic [7:0] rxbuf_q;
  sp_mode_e   mode;
  logic       nine;
  logic       mpe;

  // named internal events
  logic       tx_go;
  logic       tx_busy;
  logic       tx_done_ev;
  logic       rx_arm;
  logic       rx_done_ev;
  logic       rx_take_ev;
  logic [7:0] rx_data;
  logic       rx_b9;
  logic       rx_stop;
  logic       rb9_ev;
  logic       rb9_val;

  assign mode   = sp_mode_e'({ctl_q[CB_M0], ctl_q[CB_M1]});
  assign nine   = sp_nine(mode);
  assign mpe    = ctl_q[CB_MPE];
  assign tx_go  = txd_we && sp_active(mode);
  assign rx_arm = ctl_q[CB_REN] && sp_active(mode);

  assign rx_take_ev = rx_done_ev && sp_keep(nine, mpe, rx_b9);
  assign rb9_ev     = (rx_take_ev && nine) || (rx_done_ev && !nine && !mpe);
  assign rb9_val    = nine ? rx_b9 : rx_stop;

  sport_tx #(.OSR(OSR)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .start (tx_go),
    .nine  (nine),
    .tb9   (ctl_q[CB_TB9]),
    .data  (txd_wdata),
    .txd   (ser_tx),
    .busy  (tx_busy),
    .done  (tx_done_ev)
  );

  sport_rx #(.OSR(OSR), .SYNC(SYNC_STAGES)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .rxd   (ser_rx),
    .arm   (rx_arm),
    .nine  (nine),
    .done  (rx_done_ev),
    .data  (rx_data),
    .b9    (rx_b9),
    .stopb (rx_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rxbuf_q <= '0;
    end else begin
      if (ctl_we) ctl_q[7:2] <= ctl_wdata[7:2];
      if (rb9_ev) ctl_q[CB_RB9] <= rb9_val;
      ctl_q[CB_TF] <= sp_flag_next(ctl_q[CB_TF], ctl_we, ctl_wdata[CB_TF], tx_done_ev);
      ctl_q[CB_RF] <= sp_flag_next(ctl_q[CB_RF], ctl_we, ctl_wdata[CB_RF], rx_take_ev);
      if (rx_take_ev) rxbuf_q <= rx_data;
    end
  end

  assign ctl_rdata = ctl_q;
  assign rxd_rdata = rxbuf_q;
  assign irq       = ctl_q[CB_TF] | ctl_q[CB_RF];

endmodule

// File: rtl/sport_chk.sv
module sport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_rdata,
  input logic [7:0] rxd_rdata,
  input logic       ser_tx,
  input logic       tx_busy,
  input logic       tx_done_ev,
  input logic       rx_done_ev,
  input logic       rx_take_ev,
  input logic       rx_b9
);

  AST_TF_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_ev |=> ctl_rdata[1]); // R5

  AST_RF_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take_ev |=> ctl_rdata[0]); // R5

  AST_RXBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_take_ev |=> $stable(rxd_rdata)); // R5

  AST_TF_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[1] && !tx_done_ev) |=> !ctl_rdata[1]); // R6

  AST_RF_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[0] && !rx_take_ev) |=> !ctl_rdata[0]); // R6

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_tx); // R2

  AST_RB9_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !rx_done_ev) |=> $stable(ctl_rdata[2])); // R7

  AST_FILTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_ev && ctl_rdata[7] && ctl_rdata[5] && !rx_b9 && !ctl_we)
      |=> ($stable(rxd_rdata) && $stable(ctl_rdata[2]))); // R8

endmodule

bind sport_ctl sport_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_rdata  (ctl_rdata),
  .rxd_rdata  (rxd_rdata),
  .ser_tx     (ser_tx),
  .tx_busy    (tx_busy),
  .tx_done_ev (tx_done_ev),
  .rx_done_ev (rx_done_ev),
  .rx_take_ev (rx_take_ev),
  .rx_b9      (rx_b9)
);

// File: tb/sim_sport_ctl.sv
module sim_sport_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 8;
  localparam int TDIV       = 4;
  localparam int BITC       = OSR * TDIV;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       txd_we = 1'b0;
  logic [7:0] txd_wdata = '0;
  logic [7:0] rxd_rdata;
  logic       baud_tick = 1'b0;
  logic       ser_tx;
  logic       irq;
  logic       rxd_drv = 1'b1;
  logic       lp = 1'b0;
  logic       ser_rx;
  logic [1:0] tc = '0;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;

  assign ser_rx = lp ? ser_tx : rxd_drv;

  sport_ctl #(.OSR(OSR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .txd_we(txd_we), .txd_wdata(txd_wdata),
    .rxd_rdata(rxd_rdata), .baud_tick(baud_tick), .ser_rx(ser_rx),
    .ser_tx(ser_tx), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tc        <= tc + 2'd1;
    baud_tick <= (tc == 2'(TDIV - 1));
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- bench model functions ----
  function automatic logic m_keep(logic [1:0] m, logic mpe, logic b9);
    return !(m[1] && mpe && !b9);
  endfunction

  function automatic logic m_rb9(logic [1:0] m, logic mpe, logic b9, logic stp, logic old);
    if (m[1]) return m_keep(m, mpe, b9) ? b9 : old;
    if (!mpe) return stp;
    return old;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_tx(logic [7:0] v);
    @(negedge clk); txd_we = 1'b1; txd_wdata = v;
    @(negedge clk); txd_we = 1'b0;
  endtask

  task automatic drive_frame(logic nine, logic [7:0] d, logic b9, logic stp);
    @(negedge clk);
    rxd_drv = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = d[i]; repeat (BITC) @(negedge clk);
    end
    if (nine) begin
      rxd_drv = b9; repeat (BITC) @(negedge clk);
    end
    rxd_drv = stp; repeat (BITC) @(negedge clk);
    rxd_drv = 1'b1; repeat (BITC) @(negedge clk);
  endtask

  task automatic cap_tx(logic nine, output logic [7:0] d, output logic b9,
                        output logic stp, output logic st);
    int n = 0;
    while (ser_tx && n < 4 * BITC) begin
      @(negedge clk); n++;
    end
    repeat (BITC / 2) @(negedge clk);
    st = ser_tx;
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      d[i] = ser_tx;
    end
    b9 = 1'b0;
    if (nine) begin
      repeat (BITC) @(negedge clk);
      b9 = ser_tx;
    end
    repeat (BITC) @(negedge clk);
    stp = ser_tx;
  endtask

  task automatic wait_tf();
    int n = 0;
    while (!ctl_rdata[1] && n < 16 * BITC) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic watch_idle(int nclk, output logic low_seen);
    low_seen = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      if (!ser_tx) low_seen = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] d, rd, prev_rx;
    logic       b9, stp, st, low, seen, rb9_m;
    logic [1:0] m;
    logic       mpe, tb9, keep;
    void'($urandom(32'h5eed_0042));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 irq low
    check("R1 reset ctl", ctl_rdata, 8'h00);
    check("R1 reset ser_tx", ser_tx, 1'b1);
    check("R11 reset irq", irq, 1'b0);
    check("R1 reset rxd_rdata", rxd_rdata, 8'h00);

    // R6 ones written to flags are ignored
    wr_ctl(8'hFF);
    check("R6 write ones to flags", ctl_rdata, 8'hFC);
    check("R11 irq after ones write", irq, 1'b0);

    // R4 mode 00: transmit ignored, no reception
    wr_ctl(8'h10);
    wr_tx(8'h00);
    watch_idle(12 * BITC, low);
    check("R4 mode00 ser_tx idle", low, 1'b0);
    check("R4 mode00 no tx_flag", ctl_rdata[1], 1'b0);
    drive_frame(1'b0, 8'h5A, 1'b0, 1'b1);
    check("R4 mode00 no rx_flag", ctl_rdata[0], 1'b0);
    check("R4 mode00 rxd_rdata", rxd_rdata, 8'h00);

    // R2 8-bit frame format, R12 write while busy ignored
    wr_ctl(8'h40);
    wr_tx(8'h3C);
    wr_tx(8'hFF);
    cap_tx(1'b0, d, b9, stp, st);
    check("R2 start bit", st, 1'b0);
    check("R12/R2 data bits", d, 8'h3C);
    check("R2 stop bit", stp, 1'b1);
    wait_tf();
    @(negedge clk);
    check("R5 tx_flag after frame", ctl_rdata[1], 1'b1);
    check("R11 irq from tx_flag", irq, 1'b1);
    watch_idle(12 * BITC, low);
    check("R12 no second frame", low, 1'b0);
    wr_ctl(8'h40);
    check("R6 zero write clears tx_flag", ctl_rdata[1], 1'b0);

    // R3 ninth bit sent in modes 10 and 11
    wr_ctl(8'h88);
    wr_tx(8'hC3);
    cap_tx(1'b1, d, b9, stp, st);
    check("R3 mode10 data", d, 8'hC3);
    check("R3 mode10 ninth bit 1", b9, 1'b1);
    check("R3 mode10 stop", stp, 1'b1);
    wait_tf();
    wr_ctl(8'hC0);
    wr_tx(8'h81);
    cap_tx(1'b1, d, b9, stp, st);
    check("R3 mode11 ninth bit 0", b9, 1'b0);
    check("R3 mode11 data", d, 8'h81);
    wait_tf();
    wr_ctl(8'h40);

    // R9 receiver disabled
    drive_frame(1'b0, 8'h77, 1'b0, 1'b1);
    check("R9 ren=0 no rx_flag", ctl_rdata[0], 1'b0);
    check("R9 ren=0 rxd_rdata", rxd_rdata, 8'h00);

    // R10 short start pulse discarded, then a real frame
    wr_ctl(8'h50);
    @(negedge clk); rxd_drv = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    check("R10 glitch no rx_flag", ctl_rdata[0], 1'b0);
    drive_frame(1'b0, 8'hA5, 1'b0, 1'b1);
    check("R10 frame after glitch", rxd_rdata, 8'hA5);
    check("R5 rx_flag set", ctl_rdata[0], 1'b1);
    check("R7 mode01 stop stored", ctl_rdata[2], 1'b1);
    check("R11 irq from rx_flag", irq, 1'b1);
    // R6 writing one leaves rx_flag set
    wr_ctl(8'h51);
    check("R6 one write keeps rx_flag", ctl_rdata[0], 1'b1);
    wr_ctl(8'h50);
    check("R6 zero write clears rx_flag", ctl_rdata[0], 1'b0);

    // R7 stop bit low captured in mode 01
    drive_frame(1'b0, 8'h12, 1'b0, 1'b0);
    check("R7 stop low stored", ctl_rdata[2], 1'b0);
    // R7 mode 01 with filter on: rx_bit9 untouched
    wr_ctl(8'h70);
    drive_frame(1'b0, 8'h34, 1'b0, 1'b1);
    check("R7 filter on mode01 rb9 held", ctl_rdata[2], 1'b0);
    check("R5 mode01 filter on accepted", rxd_rdata, 8'h34);

    // R8 filtered drop, directed
    wr_ctl(8'hB4);
    drive_frame(1'b1, 8'h99, 1'b0, 1'b1);
    check("R8 drop no rx_flag", ctl_rdata[0], 1'b0);
    check("R8 drop data held", rxd_rdata, 8'h34);
    check("R8 drop rb9 held", ctl_rdata[2], 1'b1);
    drive_frame(1'b1, 8'h66, 1'b1, 1'b1);
    check("R8 address frame taken", rxd_rdata, 8'h66);
    check("R8 address rx_flag", ctl_rdata[0], 1'b1);

    // R6 hardware set wins over a held clearing write
    lp = 1'b0;
    wr_ctl(8'h40);
    wr_tx(8'h55);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h40;
    seen = 1'b0;
    for (int i = 0; i < 14 * BITC; i++) begin
      @(negedge clk);
      if (ctl_rdata[1]) seen = 1'b1;
    end
    ctl_we = 1'b0;
    @(negedge clk);
    check("R6 hw set beats clearing write", seen, 1'b1);
    check("R6 cleared by following write", ctl_rdata[1], 1'b0);

    // random loopback frames
    lp = 1'b1;
    prev_rx = rxd_rdata;
    for (int it = 0; it < 24; it++) begin
      m     = 2'($urandom_range(1, 3));
      mpe   = 1'($urandom);
      tb9   = 1'($urandom);
      rb9_m = 1'($urandom);
      d     = 8'($urandom);
      wr_ctl({m, mpe, 1'b1, tb9, rb9_m, 2'b00});
      wr_tx(d);
      wait_tf();
      repeat (4) @(negedge clk);
      keep = m_keep(m, mpe, tb9);
      if (keep) prev_rx = d;
      rd = rxd_rdata;
      check("R5 loop tx_flag", ctl_rdata[1], 1'b1);
      check("R8/R5 loop rx_flag", ctl_rdata[0], keep);
      check("R5 loop rxd_rdata", rd, prev_rx);
      check("R7 loop rx_bit9", ctl_rdata[2], m_rb9(m, mpe, tb9, 1'b1, rb9_m));
      check("R11 loop irq", irq, 1'b1);
    end
    lp = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule